// File: doc/BRIEF.md
# Calibrated Seconds Divider

This block turns a 32,768-per-second clock enable into a one-pulse-per-second tick and lets software trim the long-term rate digitally. It does not use a fixed divide ratio. Over a repeating 64-minute window, it shortens or stretches the first second of selected minutes by a whole number of 256-enable steps or half-steps. This corrects a fast or slow timebase without touching the oscillator.

An 8-bit control register sets the correction and also drives a single test/output pin. The register holds a five-bit trim magnitude, a direction bit, a test-tone enable and a static output level. With the test tone on, the pin toggles at 512 Hz from its own uncalibrated counter, so the raw timebase can be measured. With the tone off, the pin shows the static level.

The block also drives the second tick, a minute tick and a 64-minute window tick for downstream logic and for checking. A stop input freezes every counter.

Top module: `osc_cal_div`

## Requirements
- R1: While `rst_ni` is low, `sec_tick_o`, `min_tick_o` and `cyc_tick_o` are 0. The control register resets to 8'h80: output level bit 7 = 1, test-tone bit 6 = 0, direction bit 5 = 0 and magnitude bits 4:0 = 0. As a result `fout_o` is 1.
- R2: With magnitude 0, every second lasts exactly `TICKS_PER_SEC` counted enables.
- R3: With direction bit 5 = 1 (speed up) and magnitude N, the first second of each minute index below 2N lasts `TICKS_PER_SEC - POS_TRIM` enables.
- R4: With direction bit 5 = 0 (slow down) and magnitude N, the first second of each minute index below 2N lasts `TICKS_PER_SEC + NEG_TRIM` enables.
- R5: Seconds other than second 0 of a minute are never trimmed. Minutes at index 2N or above, or at index `CAL_MIN_MAX` (62) or above, run at nominal length.
- R6: `min_tick_o` fires with every `SEC_PER_MIN`-th second tick. `cyc_tick_o` fires with every `MIN_PER_CYCLE`-th minute tick. Each coincides with the tick below it.
- R7: A clock with `tick_en_i` low advances nothing.
- R8: While `stop_i` is high, no counter advances. This includes the test-tone counter, so `fout_o` holds its value and no tick is produced.
- R9: With test-tone bit 6 = 1, `fout_o` toggles after every `FT_HALF` counted enables, whatever the trim setting.
- R10: With test-tone bit 6 = 0, `fout_o` equals control bit 7.
- R11: A clock with `ctrl_we_i` high loads `ctrl_wdata_i` into the control register. The new value governs `fout_o` right after that edge and governs trimming from the next enable on.
- R12: Every tick output is a single-clock pulse. It is registered one clock after the enable that completes its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Timebase enable, nominally 32,768 per second |
| stop_i | input | 1 | Freezes all counting while high |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control value: [7] level, [6] tone, [5] direction, [4:0] magnitude |
| sec_tick_o | output | 1 | One-clock pulse per second |
| min_tick_o | output | 1 | One-clock pulse per minute |
| cyc_tick_o | output | 1 | One-clock pulse per 64-minute window |
| fout_o | output | 1 | Test tone or static level |

## Verification
The tick outputs are registered, so each pulse is due one clock after the enabled edge that completes a second. The level on `fout_o` is decoded from registers and changes right after the edge that writes the control register or toggles the tone. The bench advances a behavioural model on the same rising edge and compares all four outputs on every falling edge. This keeps each comparison half a clock away from the edge that produced the value. On top of that, second lengths are measured as clock distances between observed ticks under a continuous enable and checked against the trim rule.

// File: rtl/cal_div_pkg.sv
package cal_div_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_FAST = 2'd1,
    TRIM_SLOW = 2'd2
  } trim_e;

  typedef struct packed {
    logic       out_lvl;
    logic       tone_en;
    logic       dir_up;
    logic [4:0] mag;
  } ctrl_t;
endpackage

// File: rtl/cal_div_sec.sv
module cal_div_sec
  import cal_div_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int POS_TRIM      = 256,
  parameter int NEG_TRIM      = 128
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  trim_e trim_i,
  output logic  wrap_o,
  output logic  tick_o
);
  localparam int TCW = $clog2(TICKS_PER_SEC + NEG_TRIM + 1);
  localparam logic [TCW-1:0] NOM_M1  = TCW'(TICKS_PER_SEC - 1);
  localparam logic [TCW-1:0] FAST_M1 = TCW'(TICKS_PER_SEC - POS_TRIM - 1);
  localparam logic [TCW-1:0] SLOW_M1 = TCW'(TICKS_PER_SEC + NEG_TRIM - 1);

  logic [TCW-1:0] cnt_q;
  logic [TCW-1:0] lim_m1;
  logic           tick_q;

  always_comb begin
    unique case (trim_i)
      TRIM_FAST: lim_m1 = FAST_M1;
      TRIM_SLOW: lim_m1 = SLOW_M1;
      default:   lim_m1 = NOM_M1;
    endcase
  end

  // >= keeps the counter bounded if the limit shrinks mid-second
  assign wrap_o = adv_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      if (wrap_o)     cnt_q <= '0;
      else if (adv_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/cal_div_min.sv
module cal_div_min
  import cal_div_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int CAL_MIN_MAX   = 62
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_wrap_i,
  input  logic       dir_up_i,
  input  logic [4:0] mag_i,
  output trim_e      trim_o,
  output logic       min_tick_o,
  output logic       cyc_tick_o
);
  localparam int SW = $clog2(SEC_PER_MIN);
  localparam int MW = $clog2(MIN_PER_CYCLE);
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(MIN_PER_CYCLE - 1);

  logic [SW-1:0] sec_q;
  logic [MW-1:0] min_q;
  logic          min_tick_q, cyc_tick_q;
  logic          hit;

  // only second 0 of an eligible minute is trimmed
  assign hit = (sec_q == '0)
             && (int'(min_q) < 2 * int'(mag_i))
             && (int'(min_q) < CAL_MIN_MAX);

  always_comb begin
    if (!hit)         trim_o = TRIM_NONE;
    else if (dir_up_i) trim_o = TRIM_FAST;
    else               trim_o = TRIM_SLOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q      <= '0;
      min_q      <= '0;
      min_tick_q <= 1'b0;
      cyc_tick_q <= 1'b0;
    end else begin
      min_tick_q <= sec_wrap_i && (sec_q == SEC_LAST);
      cyc_tick_q <= sec_wrap_i && (sec_q == SEC_LAST) && (min_q == MIN_LAST);
      if (sec_wrap_i) begin
        if (sec_q == SEC_LAST) begin
          sec_q <= '0;
          min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end

  assign min_tick_o = min_tick_q;
  assign cyc_tick_o = cyc_tick_q;
endmodule

// File: rtl/cal_div_fout.sv
module cal_div_fout #(
  parameter int FT_HALF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic tone_en_i,
  input  logic out_lvl_i,
  output logic fout_o
);
  localparam int FW = $clog2(FT_HALF);
  localparam logic [FW-1:0] HALF_LAST = FW'(FT_HALF - 1);

  logic [FW-1:0] cnt_q;
  logic          sq_q;

  // free-running, never sees the trim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (adv_i) begin
      if (cnt_q == HALF_LAST) begin
        cnt_q <= '0;
        sq_q  <= ~sq_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fout_o = tone_en_i ? sq_q : out_lvl_i;
endmodule

// File: rtl/osc_cal_div.sv
module osc_cal_div
  import cal_div_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int POS_TRIM      = 256,
  parameter int NEG_TRIM      = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int CAL_MIN_MAX   = 62,
  parameter int FT_HALF       = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic       stop_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic       sec_tick_o,
  output logic       min_tick_o,
  output logic       cyc_tick_o,
  output logic       fout_o
);
  localparam logic [7:0] CTRL_RST = 8'h80;

  ctrl_t ctrl_q;
  logic  adv, sec_wrap;
  trim_e trim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= ctrl_t'(CTRL_RST);
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end

  assign adv = tick_en_i & ~stop_i;

  cal_div_sec #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .POS_TRIM     (POS_TRIM),
    .NEG_TRIM     (NEG_TRIM)
  ) u_sec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .trim_i(trim),
    .wrap_o(sec_wrap),
    .tick_o(sec_tick_o)
  );

  cal_div_min #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .CAL_MIN_MAX  (CAL_MIN_MAX)
  ) u_min (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_wrap_i(sec_wrap),
    .dir_up_i  (ctrl_q.dir_up),
    .mag_i     (ctrl_q.mag),
    .trim_o    (trim),
    .min_tick_o(min_tick_o),
    .cyc_tick_o(cyc_tick_o)
  );

  cal_div_fout #(
    .FT_HALF(FT_HALF)
  ) u_fout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .tone_en_i(ctrl_q.tone_en),
    .out_lvl_i(ctrl_q.out_lvl),
    .fout_o   (fout_o)
  );
endmodule

// File: rtl/osc_cal_div_chk.sv
module osc_cal_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_en_i,
  input logic       stop_i,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_q,
  input logic       sec_tick_o,
  input logic       min_tick_o,
  input logic       cyc_tick_o,
  input logic       fout_o
);
  AST_MIN_ON_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> sec_tick_o); // R6
  AST_CYC_ON_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_tick_o |-> min_tick_o); // R6
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> !sec_tick_o); // R7
  AST_STOP_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sec_tick_o); // R8
  AST_STOP_FOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !ctrl_we_i) |=> $stable(fout_o)); // R8
  AST_STATIC_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[6] && !ctrl_we_i) |=> $stable(fout_o)); // R10
  AST_SEC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o); // R12
endmodule

bind osc_cal_div osc_cal_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_en_i   (tick_en_i),
  .stop_i      (stop_i),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_q      (ctrl_q),
  .sec_tick_o  (sec_tick_o),
  .min_tick_o  (min_tick_o),
  .cyc_tick_o  (cyc_tick_o),
  .fout_o      (fout_o)
);

// File: tb/osc_cal_div_tb.sv
module osc_cal_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 32, POS = 8, NEG = 4, SPM = 4, MPC = 64, CMAX = 62, HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, stop = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic sec_tick_o, min_tick_o, cyc_tick_o, fout_o;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_cal_div #(
    .TICKS_PER_SEC(TPS), .POS_TRIM(POS), .NEG_TRIM(NEG),
    .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .CAL_MIN_MAX(CMAX), .FT_HALF(HALF)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .stop_i(stop),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .sec_tick_o(sec_tick_o), .min_tick_o(min_tick_o),
    .cyc_tick_o(cyc_tick_o), .fout_o(fout_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_tcnt, m_sec, m_min, m_ft;
  bit m_sq, m_st, m_mt, m_ct;
  logic [7:0] m_ctrl;
  int ccount = 0;

  function automatic int sec_len(int sidx, int midx, logic [7:0] c);
    if (sidx == 0 && midx < 2 * int'(c[4:0]) && midx < CMAX)
      return c[5] ? TPS - POS : TPS + NEG;
    return TPS;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0; m_sec = 0; m_min = 0; m_ft = 0; m_sq = 0;
      m_st = 0; m_mt = 0; m_ct = 0; m_ctrl = 8'h80;
    end else begin
      int len;
      ccount++;
      m_st = 0; m_mt = 0; m_ct = 0;
      if (tick_en && !stop) begin
        if (m_ft == HALF - 1) begin m_ft = 0; m_sq = !m_sq; end
        else m_ft++;
        len = sec_len(m_sec, m_min, m_ctrl);
        if (m_tcnt >= len - 1) begin
          m_tcnt = 0; m_st = 1;
          if (m_sec == SPM - 1) begin
            m_sec = 0; m_mt = 1;
            if (m_min == MPC - 1) begin m_min = 0; m_ct = 1; end
            else m_min++;
          end else m_sec++;
        end else m_tcnt++;
      end
      if (we) m_ctrl = wdata;
    end
  end

  bit cmp_on = 0;
  bit meas_on = 0, meas_valid = 0;
  int obs_sec = 0, obs_min = 0, last_t = 0, cyc_seen = 0;
  bit prev_st = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 R3 R4 R5 sec_tick", sec_tick_o, m_st);
      check("R6 min_tick", min_tick_o, m_mt);
      check("R6 cyc_tick", cyc_tick_o, m_ct);
      check("R9 R10 R11 fout", fout_o, m_ctrl[6] ? m_sq : m_ctrl[7]);
      if (prev_st && sec_tick_o) check("R12 single pulse", 1, 0);
    end
    prev_st = sec_tick_o;
    if (meas_on && cyc_tick_o) cyc_seen++;
    if (meas_on && sec_tick_o) begin
      if (meas_valid) begin
        int exp_len;
        exp_len = sec_len(obs_sec, obs_min, m_ctrl);
        if (m_ctrl[4:0] == 0)       check("R2 nominal length", ccount - last_t, exp_len);
        else if (exp_len == TPS)    check("R5 untrimmed length", ccount - last_t, exp_len);
        else if (m_ctrl[5])         check("R3 shortened length", ccount - last_t, exp_len);
        else                        check("R4 lengthened length", ccount - last_t, exp_len);
      end
      meas_valid = 1;
      last_t = ccount;
      if (obs_sec == SPM - 1) begin
        obs_sec = 0;
        obs_min = (obs_min == MPC - 1) ? 0 : obs_min + 1;
      end else obs_sec++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick_en = 0; stop = 0; we = 0;
    @(negedge clk);
    check("R1 sec_tick in reset", sec_tick_o, 0);
    check("R1 min_tick in reset", min_tick_o, 0);
    check("R1 cyc_tick in reset", cyc_tick_o, 0);
    check("R1 fout level in reset", fout_o, 1);
    rst_n = 1;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    we = 1; wdata = v;
    @(negedge clk);
    we = 0;
  endtask

  task automatic run_cal(input logic dir, input logic [4:0] mag, input int n);
    do_reset();
    write_ctrl({1'b1, 1'b0, dir, mag});
    obs_sec = 0; obs_min = 0; meas_valid = 0; cyc_seen = 0;
    meas_on = 1; tick_en = 1;
    repeat (n) @(negedge clk);
    meas_on = 0; tick_en = 0;
    check("R6 one window tick per 64 minutes", cyc_seen, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cmp_on = 1;
    do_reset();
    // R11 / R10: static level follows bit 7, write visible after the edge
    write_ctrl(8'h00);
    check("R11 R10 level after write 0", fout_o, 0);
    write_ctrl(8'h80);
    check("R11 R10 level after write 1", fout_o, 1);

    run_cal(1'b0, 5'd0, 8300);   // R2
    run_cal(1'b1, 5'd3, 8300);   // R3 R5
    run_cal(1'b0, 5'd31, 8500);  // R4 R5 full eligible span

    // R9: tone toggles every HALF enables regardless of trim
    do_reset();
    write_ctrl(8'h7F);
    tick_en = 1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      logic v;
      v = fout_o;
      repeat (HALF) @(negedge clk);
      check("R9 tone toggles after HALF enables", fout_o, !v);
    end

    // R8: stop freezes tone and ticks
    stop = 1;
    begin
      logic v;
      @(negedge clk);
      v = fout_o;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        check("R8 tone frozen", fout_o, v);
        check("R8 no tick while stopped", sec_tick_o, 0);
      end
    end
    stop = 0;

    // R7 R11: gated enable, stops and control changes mid-run against the model
    do_reset();
    write_ctrl(8'h25);
    for (int i = 0; i < 20000; i++) begin
      tick_en = (i % 3) != 0;
      stop = (i % 97) < 5;
      if (i == 9000) begin we = 1; wdata = 8'h4A; end
      else if (i == 15000) begin we = 1; wdata = 8'h3F; end
      else we = 0;
      @(negedge clk);
    end
    tick_en = 0; stop = 0; we = 0;

    // R7: enable low holds everything
    repeat (40) begin
      @(negedge clk);
      check("R7 no tick without enable", sec_tick_o, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule